// File: doc/BRIEF.md
# DRAM Maximum Read Latency Calculator

This unit turns a memory channel's timing settings into the largest read latency the controller must allow, counted in northbridge clocks. A request starts with a one-cycle `start` pulse. On that pulse the unit takes in these values:

- the CAS latency code
- whether the DIMMs are registered
- the three address/command setup flags
- the read-pointer initial value
- the worst-case receiver-enable delay
- two processor-specific constants, P and N
- the northbridge multiplier code
- the memory clock code

First it builds a subtotal in half-memclk units. It then makes a quarter-clock adjustment for P. Next it converts the result into the northbridge clock domain. A multi-cycle restoring divider does this conversion, dividing by the memory clock frequency that the clock code selects. A final rounded halving and the N term give the result.

The result appears on `latency` together with a one-cycle `valid` pulse. A clock code that selects no frequency skips the division. In that case the unit returns at once with `err` set.

Top module: `rd_lat_calc`

## Requirements
- R1: The subtotal, in half-memclk units, is the sum of four terms: (cas_code + 4) × 2, 2 when `registered` is 1, 1 when all of `setup_flags` are 0, and 2 when any setup flag is set.
- R2: The subtotal also gains (8 − rdptr_init) and the coarse delay rcv_dly >> 5, where rcv_dly is 9 bits wide.
- R3: The P adjustment replaces the subtotal S with floor((2·S + p_const) / 2).
- R4: The adjusted subtotal is multiplied by 200 × (nb_mult + 4). It is then divided, with truncation, by a frequency selected by mclk_code: 3→400, 4→533, 5→667, 6→800.
- R5: The quotient Q gives latency = ((Q + 1) >> 1) + (n_const >> 1), truncated to its low 10 bits.
- R6: After an accepted start, `valid` rises exactly 22 clock edges after the start edge, lasts one cycle, and comes with `err` = 0. `busy` is high from the start edge until the result is produced.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The running computation keeps its operands and its timing.
- R8: A start with mclk_code below 3 or above 6 produces `valid` = 1 and `err` = 1 on the edge after the start, with `latency` = 0 and no division.
- R9: After reset, `busy`, `valid` and `err` are 0 and `latency` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (sampled when idle) |
| cas_code | input | 4 | CAS latency code |
| registered | input | 1 | 1 when the DIMMs are registered |
| setup_flags | input | 3 | Address/command setup flags |
| rdptr_init | input | 4 | Read-pointer initial value |
| rcv_dly | input | 9 | Worst-case receiver-enable delay |
| p_const | input | 8 | Processor constant P, in quarter memclks |
| n_const | input | 8 | Processor constant N, in northbridge clocks |
| nb_mult | input | 5 | Northbridge multiplier code |
| mclk_code | input | 3 | Memory clock code |
| busy | output | 1 | Calculation in progress |
| valid | output | 1 | One-cycle result strobe |
| err | output | 1 | Unsupported clock code, qualified by valid |
| latency | output | 10 | Maximum read latency in northbridge clocks |

## Verification
A valid clock code produces its result 22 edges after the start edge. An invalid clock code produces its flagged response on the very next edge. The bench drives `start` on a falling edge and counts rising edges until `valid` is seen at a falling edge. It compares that count against 22 or 0, so a result that arrives early or late fails even when its value is correct. The start pulse issued during `busy` is checked the same way: both the value and the arrival edge must match the first request.

// File: rtl/rd_lat_calc.sv
module rd_lat_calc #(
  parameter int LAT_W  = 10,
  parameter int PROD_W = 21,
  parameter int DVS_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       cas_code,
  input  logic             registered,
  input  logic [2:0]       setup_flags,
  input  logic [3:0]       rdptr_init,
  input  logic [8:0]       rcv_dly,
  input  logic [7:0]       p_const,
  input  logic [7:0]       n_const,
  input  logic [4:0]       nb_mult,
  input  logic [2:0]       mclk_code,
  output logic             busy,
  output logic             valid,
  output logic             err,
  output logic [LAT_W-1:0] latency
);
  localparam int CNT_W = $clog2(PROD_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} state_t;
  state_t state;

  logic [11:0]       half_sub, adj_sub;
  logic [12:0]       clk_mul;
  logic [PROD_W-1:0] product;
  logic [DVS_W-1:0]  freq;
  logic              code_ok;

  assign half_sub = ((12'(cas_code) + 12'd4) << 1)
                  + (registered ? 12'd2 : 12'd0)
                  + ((|setup_flags) ? 12'd2 : 12'd1)
                  + 12'd8 - 12'(rdptr_init)
                  + 12'(rcv_dly >> 5);
  assign adj_sub  = ((half_sub << 1) + 12'(p_const)) >> 1;
  assign clk_mul  = 13'd200 * (13'(nb_mult) + 13'd4);
  assign product  = PROD_W'(adj_sub) * PROD_W'(clk_mul);
  assign code_ok  = (mclk_code >= 3'd3) && (mclk_code <= 3'd6);

  always_comb begin
    case (mclk_code)
      3'd3:    freq = DVS_W'(400);
      3'd4:    freq = DVS_W'(533);
      3'd5:    freq = DVS_W'(667);
      default: freq = DVS_W'(800);
    endcase
  end

  logic [DVS_W:0]    rem, rem_sh;
  logic [PROD_W-1:0] quo;
  logic [DVS_W-1:0]  dvs;
  logic [7:0]        n_half;
  logic [CNT_W-1:0]  cnt;
  logic              fits;

  assign rem_sh = {rem[DVS_W-1:0], quo[PROD_W-1]};
  assign fits   = rem_sh >= {1'b0, dvs};
  assign busy   = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rem     <= '0;
      quo     <= '0;
      dvs     <= '0;
      n_half  <= '0;
      cnt     <= '0;
      valid   <= 1'b0;
      err     <= 1'b0;
      latency <= '0;
    end else begin
      valid <= 1'b0;
      err   <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (code_ok) begin
            rem    <= '0;
            quo    <= product;
            dvs    <= freq;
            n_half <= n_const >> 1;
            cnt    <= CNT_W'(PROD_W);
            state  <= S_DIV;
          end else begin
            valid   <= 1'b1;
            err     <= 1'b1;
            latency <= '0;
          end
        end
        S_DIV: begin
          rem <= fits ? (rem_sh - {1'b0, dvs}) : rem_sh;
          quo <= {quo[PROD_W-2:0], fits};
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) state <= S_FIN;
        end
        default: begin
          latency <= LAT_W'(((quo + PROD_W'(1)) >> 1) + PROD_W'(n_half));
          valid   <= 1'b1;
          state   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/rd_lat_calc_chk.sv
module rd_lat_calc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] mclk_code,
  input logic       busy,
  input logic       valid,
  input logic       err,
  input logic [9:0] latency
);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mclk_code >= 3'd3 && mclk_code <= 3'd6) |=> busy && !valid);
  p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);
  p_lat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> $stable(latency));
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !err);
  p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (mclk_code < 3'd3 || mclk_code > 3'd6)) |=> valid && err && latency == 10'd0);
  p_err_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> valid);
endmodule

bind rd_lat_calc rd_lat_calc_chk u_chk (.*);

// File: tb/test_rd_lat_calc.sv
`timescale 1ns/1ps
module test_rd_lat_calc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] cas_code = '0;
  logic registered = 1'b0;
  logic [2:0] setup_flags = '0;
  logic [3:0] rdptr_init = '0;
  logic [8:0] rcv_dly = '0;
  logic [7:0] p_const = '0;
  logic [7:0] n_const = '0;
  logic [4:0] nb_mult = '0;
  logic [2:0] mclk_code = 3'd3;
  logic busy, valid, err;
  logic [9:0] latency;

  always #4 clk = ~clk;

  rd_lat_calc i_rd_lat_calc (.*);

  typedef struct packed {
    logic [3:0] cas; logic rg; logic [2:0] su; logic [3:0] rp; logic [8:0] dl;
    logic [7:0] p; logic [7:0] n; logic [4:0] m; logic [2:0] c; logic [9:0] exp;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{4'd5,  1'b0, 3'd0, 4'd6,  9'h040, 8'd29,  8'd4,   5'd6,  3'd5, 10'd57},
    '{4'd3,  1'b1, 3'd2, 4'd5,  9'h1ff, 8'd11,  8'd10,  5'd10, 3'd6, 10'd77},
    '{4'd15, 1'b1, 3'd7, 4'd0,  9'h1ff, 8'd255, 8'd255, 5'd31, 3'd3, 10'd783},
    '{4'd0,  1'b0, 3'd0, 4'd15, 9'h000, 8'd0,   8'd0,   5'd0,  3'd4, 10'd2},
    '{4'd2,  1'b0, 3'd4, 4'd7,  9'h03f, 8'd3,   8'd1,   5'd2,  3'd5, 10'd15}
  };

  int checks = 0;
  int errors = 0;
  int n_edges;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cas_code = v.cas; registered = v.rg; setup_flags = v.su; rdptr_init = v.rp;
    rcv_dly = v.dl; p_const = v.p; n_const = v.n; nb_mult = v.m; mclk_code = v.c;
  endtask

  task automatic run_to_valid(input bit poke_busy);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n_edges = 0;
    while (!valid && n_edges < 1000) begin
      @(posedge clk);
      n_edges++;
      @(negedge clk);
      if (poke_busy && n_edges == 5) begin
        apply(VEC[2]);
        start = 1'b1;
      end else start = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 busy", busy, 0);
    check("R9 valid", valid, 0);
    check("R9 err", err, 0);
    check("R9 latency", latency, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      apply(VEC[i]);
      run_to_valid(1'b0);
      check("R1,R2,R3,R4,R5 latency", latency, VEC[i].exp);
      check("R6 edges to valid", n_edges, 22);
      check("R6 err low", err, 0);
      @(negedge clk);
      check("R6 valid one cycle", valid, 0);
    end

    apply(VEC[0]);
    run_to_valid(1'b1);
    check("R7 latency kept", latency, VEC[0].exp);
    check("R7 edges kept", n_edges, 22);
    start = 1'b0;
    repeat (30) @(negedge clk);
    check("R7 no second result", busy, 0);

    apply(VEC[1]);
    mclk_code = 3'd2;
    run_to_valid(1'b0);
    check("R8 low code edges", n_edges, 0);
    check("R8 low code err", err, 1);
    check("R8 low code latency", latency, 0);
    mclk_code = 3'd7;
    @(negedge clk);
    run_to_valid(1'b0);
    check("R8 high code edges", n_edges, 0);
    check("R8 high code err", err, 1);
    @(negedge clk);
    check("R8 not busy", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule